// File: doc/BRIEF.md
# Queued Command Register With Immediate Overrides

This block is the command entry point of a bus controller. A host writes command bytes into it. Ordinary commands wait in a two-entry queue and go to an execution engine one at a time, oldest first. The engine signals each finished command with a done strobe, and the next command then moves up. Three commands never enter the queue and act in the cycle after they are written: halting DMA, resetting the controller and resetting the bus.

The host can read back the command that is executing now. When nothing is executing, the readback shows the last command that finished or took effect. An illegal-operation flag records writes that the queue had to refuse or override. A status-read strobe clears this flag. The bus-reset command drives a reset line for a time set by a clock-count parameter. The default of 1,000,000 cycles equals 25 ms at 40 MHz, and a bench can shorten it.

Command byte layout: bit 7 selects the DMA form, and bits 6:0 hold the command code. Codes used: 0x00 no-op, 0x01 clear FIFO, 0x02 reset controller, 0x03 reset bus, 0x04 halt DMA. All other codes are queued like 0x00 and 0x01.

Top module: `cmdq_ctrl`

## Requirements
- R1: After reset, eng_valid, illegal_op, bus_rst_out, dma_stop_pulse and dev_reset_pulse are 0, and host_rd_data is 0x00.
- R2: A queued command written while the queue is empty is presented in the next cycle. eng_valid is 1, eng_code equals write bits 6:0, and eng_dma equals write bit 7.
- R3: A queued command written while one is executing waits as pending. After eng_done it is presented in the next cycle, so commands run in write order.
- R4: A queued command written while both the executing and the pending entry are full is dropped, and illegal_op is set in the next cycle.
- R5: A halt-DMA write (code 0x04) is not queued. It gives a one-cycle dma_stop_pulse in the next cycle and leaves the executing entry unchanged. If an entry is pending, that entry is discarded and illegal_op is set.
- R6: A reset-controller write (code 0x02) empties both queue entries, clears illegal_op and gives a one-cycle dev_reset_pulse in the next cycle.
- R7: A reset-bus write (code 0x03) is not queued. It holds bus_rst_out high for exactly RST_CYCLES cycles starting in the next cycle, and a new reset-bus write restarts that count.
- R8: host_rd_data shows the executing command byte while eng_valid is 1. Otherwise it shows the last command that completed or took effect immediately.
- R9: stat_rd clears illegal_op in the next cycle. If a new error occurs in the same cycle, the set takes priority over the clear.
- R10: eng_done is ignored while eng_valid is 0. When a completion and a write arrive in the same cycle, the completion is applied first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host command write strobe |
| host_wr_data | input | 8 | Command byte (bit 7 = DMA form) |
| stat_rd | input | 1 | Status-read pulse, clears illegal_op |
| host_rd_data | output | 8 | Current or last command readback |
| eng_valid | output | 1 | A command is executing |
| eng_code | output | 7 | Code of the executing command |
| eng_dma | output | 1 | DMA form of the executing command |
| eng_done | input | 1 | Engine completion strobe |
| illegal_op | output | 1 | Illegal-operation flag |
| dma_stop_pulse | output | 1 | One-cycle halt-DMA request |
| dev_reset_pulse | output | 1 | One-cycle controller reset request |
| bus_rst_out | output | 1 | Timed bus reset drive |

## Verification
Directed sequences try five patterns, and each one isolates a single queue decision:
- a write to an empty queue
- a write behind a running command
- a third write against a full queue
- a halt-DMA write with and without a pending entry
- reset-controller and reset-bus writes issued while commands wait

Separate corner cases check the collisions: a completion in the same cycle as a write, a status read in the same cycle as a new error, and a completion while idle. These show whether the completion is applied before the push and whether a set beats a clear. A long seeded random run then mixes every code, with both DMA forms, against a cycle model in the bench. This exposes ordering or readback errors that appear only after many overlapping events.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
    localparam int CODE_W = 7;
    localparam int CMD_W  = CODE_W + 1;

    typedef struct packed {
        logic              dma;
        logic [CODE_W-1:0] code;
    } cmd_t;

    localparam logic [CODE_W-1:0] OP_RSTDEV = 7'h02;
    localparam logic [CODE_W-1:0] OP_RSTBUS = 7'h03;
    localparam logic [CODE_W-1:0] OP_HALT   = 7'h04;

    typedef enum logic [1:0] {
        K_QUEUE  = 2'd0,
        K_HALT   = 2'd1,
        K_RSTDEV = 2'd2,
        K_RSTBUS = 2'd3
    } kind_e;

    function automatic kind_e classify(cmd_t c);
        case (c.code)
            OP_HALT:   return K_HALT;
            OP_RSTDEV: return K_RSTDEV;
            OP_RSTBUS: return K_RSTBUS;
            default:   return K_QUEUE;
        endcase
    endfunction
endpackage

// File: rtl/cmdq_slots.sv
module cmdq_slots
    import cmdq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  cmd_t push_cmd,
    input  logic pop,
    input  logic flush,
    input  logic kill_pend,
    output logic head_v,
    output cmd_t head,
    output logic overflow,
    output logic killed,
    output logic popped,
    output cmd_t popped_cmd
);
    logic s0v, s1v;
    cmd_t s0, s1;
    logic n0v, n1v;
    cmd_t n0, n1;

    always_comb begin
        n0v = s0v; n0 = s0; n1v = s1v; n1 = s1;
        overflow = 1'b0; killed = 1'b0;
        popped = pop && s0v;
        popped_cmd = s0;
        if (popped) begin
            n0v = s1v; n0 = s1; n1v = 1'b0;
        end
        if (flush) begin
            n0v = 1'b0; n1v = 1'b0;
        end else if (kill_pend && n1v) begin
            n1v = 1'b0; killed = 1'b1;
        end
        if (push) begin
            if (!n0v) begin
                n0v = 1'b1; n0 = push_cmd;
            end else if (!n1v) begin
                n1v = 1'b1; n1 = push_cmd;
            end else begin
                overflow = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s0v <= 1'b0; s1v <= 1'b0;
            s0 <= '0; s1 <= '0;
        end else begin
            s0v <= n0v; s1v <= n1v;
            s0 <= n0; s1 <= n1;
        end
    end

    assign head_v = s0v;
    assign head   = s0;

    // R3
    pend_behind_head_chk: assert property (@(posedge clk) disable iff (rst)
        s1v |-> s0v);
endmodule

// File: rtl/cmdq_busrst.sv
module cmdq_busrst #(
    parameter int RST_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(RST_CYCLES);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (start)       cnt <= LOAD;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign active = (cnt != '0);

    // R7
    busrst_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> active);
endmodule

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl
    import cmdq_pkg::*;
#(
    parameter int RST_CYCLES = 1_000_000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_wr_en,
    input  logic [CMD_W-1:0]    host_wr_data,
    input  logic                stat_rd,
    output logic [CMD_W-1:0]    host_rd_data,
    output logic                eng_valid,
    output logic [CODE_W-1:0]   eng_code,
    output logic                eng_dma,
    input  logic                eng_done,
    output logic                illegal_op,
    output logic                dma_stop_pulse,
    output logic                dev_reset_pulse,
    output logic                bus_rst_out
);
    cmd_t  wcmd;
    kind_e kind;
    logic  wr_q, wr_halt, wr_rdev, wr_rbus;
    logic  head_v, overflow, killed, popped;
    cmd_t  head, popped_cmd, last_cmd;
    logic  err_set, err_clr;

    assign wcmd    = cmd_t'(host_wr_data);
    assign kind    = classify(wcmd);
    assign wr_q    = host_wr_en && (kind == K_QUEUE);
    assign wr_halt = host_wr_en && (kind == K_HALT);
    assign wr_rdev = host_wr_en && (kind == K_RSTDEV);
    assign wr_rbus = host_wr_en && (kind == K_RSTBUS);

    cmdq_slots u_slots (
        .clk       (clk),
        .rst       (rst),
        .push      (wr_q),
        .push_cmd  (wcmd),
        .pop       (eng_done),
        .flush     (wr_rdev),
        .kill_pend (wr_halt),
        .head_v    (head_v),
        .head      (head),
        .overflow  (overflow),
        .killed    (killed),
        .popped    (popped),
        .popped_cmd(popped_cmd)
    );

    cmdq_busrst #(.RST_CYCLES(RST_CYCLES)) u_busrst (
        .clk   (clk),
        .rst   (rst),
        .start (wr_rbus),
        .active(bus_rst_out)
    );

    assign err_set = overflow || killed;
    assign err_clr = stat_rd || wr_rdev;

    always_ff @(posedge clk) begin
        if (rst) begin
            illegal_op      <= 1'b0;
            last_cmd        <= '0;
            dma_stop_pulse  <= 1'b0;
            dev_reset_pulse <= 1'b0;
        end else begin
            if (err_set)      illegal_op <= 1'b1;
            else if (err_clr) illegal_op <= 1'b0;
            if (wr_halt || wr_rdev || wr_rbus) last_cmd <= wcmd;
            else if (popped)                   last_cmd <= popped_cmd;
            dma_stop_pulse  <= wr_halt;
            dev_reset_pulse <= wr_rdev;
        end
    end

    assign eng_valid    = head_v;
    assign eng_code     = head.code;
    assign eng_dma      = head.dma;
    assign host_rd_data = head_v ? head : last_cmd;

    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> illegal_op);
    // R5
    halt_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_halt |=> dma_stop_pulse);
    // R6
    rdev_flush_chk: assert property (@(posedge clk) disable iff (rst)
        wr_rdev |=> (!eng_valid && !illegal_op && dev_reset_pulse));
    // R10
    idle_done_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_done && !eng_valid && !host_wr_en) |=> !eng_valid);
endmodule

// File: tb/cmdq_ctrl_tb.sv
module cmdq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RSTN = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic wr = 1'b0, srd = 1'b0, done = 1'b0;
    logic [7:0] wd = '0;
    logic [7:0] rd;
    logic ev, edma, ill, stp, dvr, brst;
    logic [6:0] ecode;

    int total = 0, fails = 0;
    bit finished = 0;

    // bench model
    logic mv0 = 0, mv1 = 0, mill = 0, mstop = 0, mdev = 0;
    logic [7:0] mc0 = 0, mc1 = 0, mlast = 0;
    int mcnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdq_ctrl #(.RST_CYCLES(RSTN)) u_dut (
        .clk(clk), .rst(rst), .host_wr_en(wr), .host_wr_data(wd),
        .stat_rd(srd), .host_rd_data(rd), .eng_valid(ev), .eng_code(ecode),
        .eng_dma(edma), .eng_done(done), .illegal_op(ill),
        .dma_stop_pulse(stp), .dev_reset_pulse(dvr), .bus_rst_out(brst));

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic set, clr;
        set = 0; clr = srd; mstop = 0; mdev = 0;
        if (done && mv0) begin mlast = mc0; mc0 = mc1; mv0 = mv1; mv1 = 0; end
        if (mcnt > 0) mcnt--;
        if (wr) begin
            case (wd[6:0])
                7'h04: begin mstop = 1; mlast = wd; if (mv1) begin mv1 = 0; set = 1; end end
                7'h02: begin mdev = 1; mv0 = 0; mv1 = 0; clr = 1; mlast = wd; end
                7'h03: begin mcnt = RSTN; mlast = wd; end
                default: begin
                    if (!mv0) begin mv0 = 1; mc0 = wd; end
                    else if (!mv1) begin mv1 = 1; mc1 = wd; end
                    else set = 1;
                end
            endcase
        end
        if (set) mill = 1; else if (clr) mill = 0;
    endtask

    task automatic compare();
        chk("R3 eng_valid", ev, mv0);
        if (mv0) begin
            chk("R2 eng_code", ecode, mc0[6:0]);
            chk("R2 eng_dma", edma, mc0[7]);
        end
        chk("R8 readback", rd, mv0 ? mc0 : mlast);
        chk("R4 illegal", ill, mill);
        chk("R5 stop pulse", stp, mstop);
        chk("R6 dev pulse", dvr, mdev);
        chk("R7 bus reset", brst, mcnt > 0);
    endtask

    // inputs set at negedge; edge; model; compare at next negedge
    task automatic step(logic w, logic [7:0] d, logic dn, logic s);
        wr = w; wd = d; done = dn; srd = s;
        @(posedge clk);
        model_step();
        @(negedge clk);
        wr = 0; done = 0; srd = 0;
        compare();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int cyc;
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst = 0;
        // R1
        chk("R1 eng_valid", ev, 0); chk("R1 illegal", ill, 0);
        chk("R1 bus_rst", brst, 0); chk("R1 readback", rd, 8'h00);
        chk("R1 pulses", {stp, dvr}, 0);

        // R2 empty queue, DMA form
        step(1, 8'h91, 0, 0);
        chk("R2 valid", ev, 1); chk("R2 code", ecode, 7'h11); chk("R2 dma", edma, 1);
        // R3 pending then order
        step(1, 8'h01, 0, 0);
        step(1, 8'h45, 0, 0);                 // R4 third write dropped
        chk("R4 illegal set", ill, 1);
        step(0, 0, 1, 0);
        chk("R3 promoted", ecode, 7'h01);
        // R9 clear by status read
        step(0, 0, 0, 1);
        chk("R9 cleared", ill, 0);
        // R5 halt with pending
        step(1, 8'h22, 0, 0);
        step(1, 8'h84, 0, 0);
        chk("R5 pulse", stp, 1); chk("R5 head kept", ecode, 7'h01); chk("R5 illegal", ill, 1);
        step(0, 0, 1, 0);
        chk("R5 pending gone", ev, 0);
        // R5 halt without pending: no error
        step(0, 0, 0, 1);
        step(1, 8'h04, 0, 0);
        chk("R5 no error", ill, 0);
        // R9 set wins over clear
        step(1, 8'h10, 0, 0); step(1, 8'h11, 0, 0);
        step(1, 8'h12, 0, 1);
        chk("R9 set wins", ill, 1);
        // R6 reset controller flushes
        step(1, 8'h02, 0, 0);
        chk("R6 flushed", ev, 0); chk("R6 illegal cleared", ill, 0);
        chk("R8 last immediate", rd, 8'h02);
        // R10 done while idle ignored
        step(0, 0, 1, 0);
        chk("R10 idle done", ev, 0);
        // R10 done and write together
        step(1, 8'h30, 0, 0); step(1, 8'h31, 0, 0);
        step(1, 8'h32, 1, 0);
        chk("R10 done first", ill, 0); chk("R10 head", ecode, 7'h31);
        // R7 reset-bus length
        step(1, 8'h03, 0, 0);
        cyc = 1;
        while (brst && cyc < 100) begin step(0, 0, 0, 0); if (brst) cyc++; end
        chk("R7 length", cyc, RSTN);
        chk("R8 head shown", rd, 8'h31);

        // random
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] d;
            int r;
            r = $urandom_range(0, 11);
            d[6:0] = (r < 8) ? 7'(r) : 7'($urandom_range(5, 127));
            d[7] = 1'($urandom_range(0, 1));
            step($urandom_range(0, 9) < 4, d, $urandom_range(0, 9) < 3,
                 $urandom_range(0, 9) == 0);
        end

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule